// File: doc/BRIEF.md
# Output Compare Reference Generator

This block is a single output-compare channel of a timer. Software places a compare value in a preload register. That value reaches a shadow register either on the write itself or, when buffering is turned on, at the next update event. The channel compares only the shadow register against the running timer count, which arrives from outside the block. From that comparison it forms two results: whether the count equals the compare value, and whether it is greater.

A 3-bit mode field turns these results into a registered reference level. The level can be held, set, cleared or toggled on a match, forced to either value, or driven as a pulse-width waveform of either sense.

An external clear input can force the reference low when clearing is enabled. The clear holds the reference low until an update event releases it. The reference is also copied to a second output that feeds a master-mode trigger controller. Each equality sets a one-cycle match flag, and that flag can raise an interrupt request.

Top module: `cmp_ref_channel`

## Requirements
- R1: While reset is asserted and at the first clock edge after it is released, refOut, trigRef, cmpMatch and irq are 0, and the shadow compare value is 0.
- R2: With preloadEn=0, a write (wrEn=1) places wrData in the preload and shadow registers at the same clock edge. The comparison uses the new value from the next cycle on.
- R3: With preloadEn=1, a write changes only the preload register. The shadow register takes the preload value at a clock edge where updEvt=1. If wrEn and updEvt are high in the same cycle, the shadow takes the preload value held before that edge.
- R4: Match modes, evaluated at each clock edge where cnt equals the shadow value: mode 001 sets the reference to 1, mode 010 clears it to 0, and mode 011 inverts it. With no match, the level keeps its value.
- R5: In mode 000 the reference keeps its value whatever the count is.
- R6: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at every edge, regardless of the comparison.
- R7: Mode 110 gives reference 1 after an edge where cnt <= shadow, and 0 otherwise.
- R8: Mode 111 gives reference 1 after an edge where cnt > shadow, and 0 otherwise.
- R9: An edge with clrEn=1 and extClr=1 forces refOut low from that edge on. It stays low until a later edge that has updEvt=1 and no active clear. extClr has no effect while clrEn=0.
- R10: cmpMatch is 1 for the cycle after each edge where cnt equals the shadow value. irq equals cmpMatch gated by irqEn.
- R11: trigRef always carries the same value as refOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cnt | input | CNT_W | Running timer count |
| wrEn | input | 1 | Compare value write strobe |
| wrData | input | CNT_W | Compare value to write |
| preloadEn | input | 1 | 1: shadow loads only on update events |
| updEvt | input | 1 | Update event strobe |
| mode | input | 3 | Reference mode field |
| clrEn | input | 1 | Enables the external clear |
| extClr | input | 1 | External reference clear request |
| irqEn | input | 1 | Interrupt enable for the match flag |
| refOut | output | 1 | Reference level |
| trigRef | output | 1 | Reference copy for the trigger controller |
| cmpMatch | output | 1 | One-cycle compare match flag |
| irq | output | 1 | Match interrupt request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a write and an update event while buffering is on. The bench raises wrEn and updEvt together with a fresh value. It then presents the older preload value on the count and expects a match, which shows the shadow took the value held before that edge. A later update then brings in the fresh value.

The second pair is a clear request arriving in the same cycle as an update event. The bench expects the reference to stay low. It is released only by a following update edge that has no clear.

// File: rtl/cmp_ref_pkg.sv
package cmp_ref_pkg;

  typedef enum logic [2:0] {
    MODE_HOLD   = 3'b000,
    MODE_SETHI  = 3'b001,
    MODE_SETLO  = 3'b010,
    MODE_TOGGLE = 3'b011,
    MODE_LOW    = 3'b100,
    MODE_HIGH   = 3'b101,
    MODE_PWMA   = 3'b110,
    MODE_PWMB   = 3'b111
  } refMode_t;

  typedef struct packed {
    logic wrToShadow;
    logic preToShadow;
    logic refLoad;
    logic refVal;
    logic clrSet;
    logic clrRel;
  } refStrobe_t;

endpackage

// File: rtl/cmp_ref_ctrl.sv
module cmp_ref_ctrl
  import cmp_ref_pkg::*;
(
  input  logic       wrEn,
  input  logic       preloadEn,
  input  logic       updEvt,
  input  logic [2:0] mode,
  input  logic       clrEn,
  input  logic       extClr,
  input  logic       eqNow,
  input  logic       gtNow,
  input  logic       refLvl,
  output refStrobe_t strb
);

  refMode_t modeSel;
  assign modeSel = refMode_t'(mode);

  always_comb begin
    strb.wrToShadow  = wrEn && !preloadEn;
    strb.preToShadow = updEvt && preloadEn;
    strb.clrSet      = clrEn && extClr;
    strb.clrRel      = updEvt && !(clrEn && extClr);
    strb.refLoad     = 1'b0;
    strb.refVal      = refLvl;
    unique case (modeSel)
      MODE_HOLD: begin
        strb.refLoad = 1'b0;
        strb.refVal  = refLvl;
      end
      MODE_SETHI: begin
        strb.refLoad = eqNow;
        strb.refVal  = 1'b1;
      end
      MODE_SETLO: begin
        strb.refLoad = eqNow;
        strb.refVal  = 1'b0;
      end
      MODE_TOGGLE: begin
        strb.refLoad = eqNow;
        strb.refVal  = !refLvl;
      end
      MODE_LOW: begin
        strb.refLoad = 1'b1;
        strb.refVal  = 1'b0;
      end
      MODE_HIGH: begin
        strb.refLoad = 1'b1;
        strb.refVal  = 1'b1;
      end
      MODE_PWMA: begin
        strb.refLoad = 1'b1;
        strb.refVal  = !gtNow;
      end
      MODE_PWMB: begin
        strb.refLoad = 1'b1;
        strb.refVal  = gtNow;
      end
      default: begin
        strb.refLoad = 1'b0;
        strb.refVal  = refLvl;
      end
    endcase
  end

endmodule

// File: rtl/cmp_ref_dp.sv
module cmp_ref_dp
  import cmp_ref_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  refStrobe_t       strb,
  output logic [CNT_W-1:0] shadowVal,
  output logic             eqNow,
  output logic             gtNow,
  output logic             refLvl,
  output logic             clrHold,
  output logic             matchQ
);

  logic [CNT_W-1:0] preloadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preloadVal <= '0;
    end else if (wrEn) begin
      preloadVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowVal <= '0;
    end else if (strb.wrToShadow) begin
      shadowVal <= wrData;
    end else if (strb.preToShadow) begin
      shadowVal <= preloadVal;
    end
  end

  assign eqNow = (cnt == shadowVal);
  assign gtNow = (cnt > shadowVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refLvl  <= 1'b0;
      clrHold <= 1'b0;
      matchQ  <= 1'b0;
    end else begin
      if (strb.refLoad) refLvl <= strb.refVal;
      if (strb.clrSet) clrHold <= 1'b1;
      else if (strb.clrRel) clrHold <= 1'b0;
      matchQ <= eqNow;
    end
  end

  // shadow holds while buffered and no update arrives (R3)
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrToShadow && !strb.preToShadow) |=> $stable(shadowVal));

endmodule

// File: rtl/cmp_ref_channel.sv
module cmp_ref_channel
  import cmp_ref_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             preloadEn,
  input  logic             updEvt,
  input  logic [2:0]       mode,
  input  logic             clrEn,
  input  logic             extClr,
  input  logic             irqEn,
  output logic             refOut,
  output logic             trigRef,
  output logic             cmpMatch,
  output logic             irq
);

  refStrobe_t       strb;
  logic [CNT_W-1:0] shadowVal;
  logic             eqNow;
  logic             gtNow;
  logic             refLvl;
  logic             clrHold;
  logic             matchQ;

  cmp_ref_ctrl u_ctrl (
    .wrEn      (wrEn),
    .preloadEn (preloadEn),
    .updEvt    (updEvt),
    .mode      (mode),
    .clrEn     (clrEn),
    .extClr    (extClr),
    .eqNow     (eqNow),
    .gtNow     (gtNow),
    .refLvl    (refLvl),
    .strb      (strb)
  );

  cmp_ref_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cnt       (cnt),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .strb      (strb),
    .shadowVal (shadowVal),
    .eqNow     (eqNow),
    .gtNow     (gtNow),
    .refLvl    (refLvl),
    .clrHold   (clrHold),
    .matchQ    (matchQ)
  );

  assign refOut   = refLvl && !clrHold;
  assign trigRef  = refOut;
  assign cmpMatch = matchQ;
  assign irq      = matchQ && irqEn;

  p_direct_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !preloadEn) |=> (shadowVal == $past(wrData)));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TOGGLE && cnt == shadowVal) |=> (refLvl != $past(refLvl)));

  p_force_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOW) |=> !refOut);

  p_force_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HIGH) |=> refLvl);

  p_clear_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && extClr) |=> !refOut);

  p_match_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == shadowVal) |=> cmpMatch);

endmodule

// File: tb/cmp_ref_channel_tb.sv
module cmp_ref_channel_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] cnt;
  logic         wrEn;
  logic [W-1:0] wrData;
  logic         preloadEn;
  logic         updEvt;
  logic [2:0]   mode;
  logic         clrEn;
  logic         extClr;
  logic         irqEn;
  logic         refOut;
  logic         trigRef;
  logic         cmpMatch;
  logic         irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cmp_ref_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .cnt(cnt), .wrEn(wrEn), .wrData(wrData),
    .preloadEn(preloadEn), .updEvt(updEvt), .mode(mode), .clrEn(clrEn),
    .extClr(extClr), .irqEn(irqEn), .refOut(refOut), .trigRef(trigRef),
    .cmpMatch(cmpMatch), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkRef(input string tag, input bit exp);
    chk(refOut == exp, tag, refOut, exp);
    chk(trigRef == refOut, "R11 trigRef mirrors refOut", trigRef, refOut);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wrEn = 0; updEvt = 0; extClr = 0;
  endtask

  task automatic setCmp(input int v);
    preloadEn = 0; wrEn = 1; wrData = W'(v); cnt = 16'd7;
    step();
    idle();
  endtask

  task automatic t_reset();
    rstN = 0; cnt = 16'd5; wrEn = 0; wrData = '0; preloadEn = 0; updEvt = 0;
    mode = 3'b101; clrEn = 0; extClr = 0; irqEn = 1;
    step(); step();
    chkRef("R1 reset refOut", 0);
    chk(cmpMatch == 0, "R1 reset cmpMatch", cmpMatch, 0);
    chk(irq == 0, "R1 reset irq", irq, 0);
    rstN = 1; mode = 3'b000; cnt = 16'd0;
    step();
    chk(cmpMatch == 1, "R1 shadow zero after reset", cmpMatch, 1);
    cnt = 16'd5;
    step();
  endtask

  task automatic t_direct();
    setCmp(100);
    cnt = 16'd100; irqEn = 1;
    step();
    chk(cmpMatch == 1, "R2 direct write compares", cmpMatch, 1);
    chk(irq == 1, "R10 irq with enable", irq, 1);
    irqEn = 0; cnt = 16'd100;
    step();
    chk(irq == 0, "R10 irq masked", irq, 0);
    cnt = 16'd101;
    step();
    chk(cmpMatch == 0, "R10 flag drops without match", cmpMatch, 0);
  endtask

  task automatic t_preload();
    preloadEn = 1; wrEn = 1; wrData = 16'd200; cnt = 16'd7;
    step();
    idle(); cnt = 16'd200;
    step();
    chk(cmpMatch == 0, "R3 buffered write not yet visible", cmpMatch, 0);
    cnt = 16'd100;
    step();
    chk(cmpMatch == 1, "R3 old shadow still active", cmpMatch, 1);
    wrEn = 1; wrData = 16'd300; updEvt = 1; cnt = 16'd7;
    step();
    idle(); cnt = 16'd200;
    step();
    chk(cmpMatch == 1, "R3 write+update takes old preload", cmpMatch, 1);
    updEvt = 1; cnt = 16'd7;
    step();
    idle(); cnt = 16'd300;
    step();
    chk(cmpMatch == 1, "R3 next update brings new value", cmpMatch, 1);
    preloadEn = 0;
  endtask

  task automatic t_match_modes();
    setCmp(50);
    mode = 3'b101; step();
    chkRef("R6 force high", 1);
    mode = 3'b010; cnt = 16'd49; step();
    chkRef("R4 clear mode no match keeps", 1);
    cnt = 16'd50; step();
    chkRef("R4 clear on match", 0);
    mode = 3'b001; cnt = 16'd49; step();
    chkRef("R4 set mode no match keeps", 0);
    cnt = 16'd50; step();
    chkRef("R4 set on match", 1);
    mode = 3'b011; step();
    chkRef("R4 toggle first", 0);
    step();
    chkRef("R4 toggle second", 1);
    cnt = 16'd51; step();
    chkRef("R4 toggle no match keeps", 1);
  endtask

  task automatic t_freeze_force();
    setCmp(50);
    mode = 3'b101; step();
    mode = 3'b000; cnt = 16'd50; step();
    chkRef("R5 hold high", 1);
    mode = 3'b100; step();
    chkRef("R6 force low at match", 0);
    mode = 3'b000; cnt = 16'd10; step();
    chkRef("R5 hold low", 0);
  endtask

  task automatic t_pwm();
    setCmp(50);
    mode = 3'b110;
    cnt = 16'd49; step(); chkRef("R7 pwm1 below", 1);
    cnt = 16'd50; step(); chkRef("R7 pwm1 equal", 1);
    cnt = 16'd51; step(); chkRef("R7 pwm1 above", 0);
    mode = 3'b111;
    cnt = 16'd49; step(); chkRef("R8 pwm2 below", 0);
    cnt = 16'd50; step(); chkRef("R8 pwm2 equal", 0);
    cnt = 16'd51; step(); chkRef("R8 pwm2 above", 1);
  endtask

  task automatic t_clear();
    mode = 3'b101; preloadEn = 0; cnt = 16'd7;
    clrEn = 0; extClr = 1; step();
    chkRef("R9 clear ignored when disabled", 1);
    clrEn = 1; extClr = 1; step();
    chkRef("R9 clear forces low", 0);
    extClr = 0; step(); step();
    chkRef("R9 clear holds", 0);
    extClr = 1; updEvt = 1; step();
    chkRef("R9 clear with update stays low", 0);
    extClr = 0; updEvt = 1; step();
    updEvt = 0;
    chkRef("R9 update releases", 1);
    clrEn = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_direct();
    t_preload();
    t_match_modes();
    t_freeze_force();
    t_pwm();
    t_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule